// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block is an 8-bit status register that holds the pending flags for five timer events and turns them into interrupt requests. The events are compare match A, compare match B, input capture, timer-0 overflow and timer-1 overflow. Each event source sets its flag from the hardware side. Software clears a flag by writing a one to its bit position. The interrupt controller clears a flag by pulsing that flag's acknowledge line when it takes the vector. Every flag drives its own request line, gated by a per-flag enable and a global interrupt enable.

Each event input can be a single-cycle pulse or a level condition, chosen per source by a parameter. A level source passes through an edge-detect state machine with states `EV_LOW` and `EV_HIGH`. Transition `EV_RISE` (`EV_LOW` to `EV_HIGH`, the level is seen high) sends a one-cycle set pulse. Transition `EV_DROP` (`EV_HIGH` to `EV_LOW`, the level is seen low) rearms the detector. Each flag is a state machine with states `FLAG_IDLE` and `FLAG_PEND`. Transition `FLAG_RAISE` (`FLAG_IDLE` to `FLAG_PEND`) happens on a set pulse. Transition `FLAG_DROP` (`FLAG_PEND` to `FLAG_IDLE`) happens on a clear in a cycle that has no set pulse.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset, and whenever `rst_n` is low, `rd_data` reads 0x00 and every bit of `irq_o` is 0.
- R2: Event sources map to register bits as follows: `evt_i[0]` (compare A) to bit 6, `evt_i[1]` (compare B) to bit 5, `evt_i[2]` (capture) to bit 3, `evt_i[3]` (timer-0 overflow) to bit 1 and `evt_i[4]` (timer-1 overflow) to bit 7. A set event sampled at a clock edge shows on `rd_data` after that edge.
- R3: Bits 4, 2 and 0 always read 0. Writing ones to them changes no flag.
- R4: A write with `wr_en` high clears every flag whose bit in `wr_data` is 1. Flags whose bit is 0 keep their value.
- R5: A high `ack_i[k]` at a clock edge clears the flag of source k.
- R6: `irq_o[k]` is 1 exactly when `gie_i`, `ie_mask_i[k]` and the flag of source k are all 1.
- R7: A level-mode source (sources 0 and 1 by default) sets its flag only on a low-to-high change of its input. If the flag is cleared while the input stays high, the flag stays clear until the input goes low and then high again.
- R8: When a set event and a clear (by write or by acknowledge) reach the same flag at the same edge, the flag ends up set.
- R9: A pulse-mode source (sources 2 to 4 by default) sets its flag at every edge where its input is high, including consecutive edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 5 | Event inputs, one per source (pulse or level per parameter) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; a one clears the matching flag |
| rd_data | output | 8 | Register read value |
| ack_i | input | 5 | Per-source vector-taken acknowledge |
| ie_mask_i | input | 5 | Per-source interrupt enable |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 5 | Per-source interrupt request |

## Verification
A hardware set and a clear can reach the same flag at the same clock edge. The clear can be a software write of a one or an acknowledge from the interrupt controller. The bench provokes this with a rising level on compare B while a write clears both compare bits. It also pulses timer-1 overflow in the same cycle as its acknowledge. Both cases are judged on `rd_data` after that edge: the flag that received the set must still read one, and the flag that only received the clear must read zero.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
    localparam int NUM_SRC = 5;
    localparam int REG_W   = 8;

    // register bit position of each event source
    localparam int SRC_BIT [NUM_SRC] = '{6, 5, 3, 1, 7};

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_PEND = 1'b1
    } flag_state_t;

    typedef enum logic {
        EV_LOW  = 1'b0,
        EV_HIGH = 1'b1
    } ev_state_t;
endpackage

// File: rtl/tmr_irq_edge_fsm.sv
module tmr_irq_edge_fsm
    import tmr_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic pulse_o
);
    ev_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EV_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_LOW:  if (lvl_i)  state_d = EV_HIGH;   // EV_RISE
            EV_HIGH: if (!lvl_i) state_d = EV_LOW;    // EV_DROP
            default: state_d = EV_LOW;
        endcase
    end

    always_comb begin
        pulse_o = (state_q == EV_LOW) && lvl_i;
    end

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
endmodule

// File: rtl/tmr_irq_flag_fsm.sv
module tmr_irq_flag_fsm
    import tmr_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (set_i)           state_d = FLAG_PEND;  // FLAG_RAISE
            FLAG_PEND: if (clr_i && !set_i) state_d = FLAG_IDLE;  // FLAG_DROP
            default:   state_d = FLAG_IDLE;
        endcase
    end

    always_comb begin
        pend_o = (state_q == FLAG_PEND);
    end

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_o);

    // R5
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !pend_o);

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(pend_o));
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
    import tmr_irq_pkg::*;
#(
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = 5'b00011
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    input  logic [NUM_SRC-1:0] ack_i,
    input  logic [NUM_SRC-1:0] ie_mask_i,
    input  logic               gie_i,
    output logic [NUM_SRC-1:0] irq_o
);
    logic [NUM_SRC-1:0] src_set;
    logic [NUM_SRC-1:0] src_clr;
    logic [NUM_SRC-1:0] pend;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        if (LEVEL_MASK[k]) begin : g_level
            tmr_irq_edge_fsm i_edge (
                .clk     (clk),
                .rst_n   (rst_n),
                .lvl_i   (evt_i[k]),
                .pulse_o (src_set[k])
            );
        end else begin : g_pulse
            assign src_set[k] = evt_i[k];
        end

        assign src_clr[k] = (wr_en && wr_data[SRC_BIT[k]]) || ack_i[k];

        tmr_irq_flag_fsm i_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (src_set[k]),
            .clr_i  (src_clr[k]),
            .pend_o (pend[k])
        );

        // R4
        wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[SRC_BIT[k]] && !src_set[k]) |=> !rd_data[SRC_BIT[k]]);
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            rd_data[SRC_BIT[k]] = pend[k];
        end
    end

    assign irq_o = pend & ie_mask_i & {NUM_SRC{gie_i}};

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_o) |-> gie_i);
endmodule

// File: tb/test_tmr_irq_flags.sv
module test_tmr_irq_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] evt_i = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [4:0] ack_i = '0;
    logic [4:0] ie_mask_i = '0;
    logic       gie_i = 1'b0;
    logic [4:0] irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr_irq_flags i_tmr_irq_flags (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .ack_i(ack_i),
        .ie_mask_i(ie_mask_i), .gie_i(gie_i), .irq_o(irq_o)
    );

    // {evt, wr_en, wr_data, ack, ie, gie, exp_rd, exp_irq}
    localparam int NV = 20;
    localparam logic [37:0] TBL [NV] = '{
        {5'b00100, 1'b0, 8'h00, 5'b00000, 5'b00000, 1'b0, 8'h08, 5'b00000},
        {5'b00000, 1'b0, 8'h00, 5'b00000, 5'b00100, 1'b0, 8'h08, 5'b00000},
        {5'b00000, 1'b0, 8'h00, 5'b00000, 5'b00100, 1'b1, 8'h08, 5'b00100},
        {5'b01000, 1'b0, 8'h00, 5'b00000, 5'b00100, 1'b1, 8'h0A, 5'b00100},
        {5'b10000, 1'b0, 8'h00, 5'b00000, 5'b11111, 1'b1, 8'h8A, 5'b11100},
        {5'b00000, 1'b1, 8'h08, 5'b00000, 5'b11111, 1'b1, 8'h82, 5'b11000},
        {5'b00000, 1'b1, 8'h00, 5'b00000, 5'b11111, 1'b1, 8'h82, 5'b11000},
        {5'b00000, 1'b1, 8'h15, 5'b00000, 5'b11111, 1'b1, 8'h82, 5'b11000},
        {5'b00000, 1'b0, 8'h00, 5'b01000, 5'b11111, 1'b1, 8'h80, 5'b10000},
        {5'b00001, 1'b0, 8'h00, 5'b00000, 5'b11111, 1'b1, 8'hC0, 5'b10001},
        {5'b00001, 1'b1, 8'h40, 5'b00000, 5'b11111, 1'b1, 8'h80, 5'b10000},
        {5'b00001, 1'b0, 8'h00, 5'b00000, 5'b11111, 1'b1, 8'h80, 5'b10000},
        {5'b00000, 1'b0, 8'h00, 5'b00000, 5'b11111, 1'b1, 8'h80, 5'b10000},
        {5'b00001, 1'b0, 8'h00, 5'b00000, 5'b11111, 1'b1, 8'hC0, 5'b10001},
        {5'b00011, 1'b1, 8'h60, 5'b00000, 5'b11111, 1'b1, 8'hA0, 5'b10010},
        {5'b10000, 1'b0, 8'h00, 5'b10000, 5'b11111, 1'b1, 8'hA0, 5'b10010},
        {5'b00000, 1'b1, 8'h80, 5'b00000, 5'b11111, 1'b1, 8'h20, 5'b00010},
        {5'b10000, 1'b0, 8'h00, 5'b00000, 5'b11111, 1'b1, 8'hA0, 5'b10010},
        {5'b10000, 1'b1, 8'h80, 5'b00000, 5'b11111, 1'b0, 8'hA0, 5'b00000},
        {5'b00000, 1'b0, 8'h00, 5'b11111, 5'b11111, 1'b1, 8'h00, 5'b00000}
    };

    function automatic string row_req(input int r);
        case (r)
            0, 3, 4:   return "R2";
            1, 2:      return "R6";
            5, 6:      return "R4";
            7:         return "R3";
            8:         return "R5";
            9, 10, 11, 12, 13: return "R7";
            14, 15:    return "R8";
            16, 17:    return "R9";
            18:        return "R9/R6";
            default:   return "R5";
        endcase
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check5(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: irq_o actual %b expected %b", req, act, exp);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        ie_mask_i = 5'b11111;
        gie_i = 1'b1;
        #5;
        // R1: held in reset
        check8("R1", rd_data, 8'h00);
        check5("R1", irq_o, 5'b00000);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check8("R1", rd_data, 8'h00);

        for (int r = 0; r < NV; r++) begin
            @(negedge clk);
            evt_i     = TBL[r][37:33];
            wr_en     = TBL[r][32];
            wr_data   = TBL[r][31:24];
            ack_i     = TBL[r][23:19];
            ie_mask_i = TBL[r][18:14];
            gie_i     = TBL[r][13];
            @(posedge clk); #1;
            check8(row_req(r), rd_data, TBL[r][12:5]);
            check5(row_req(r), irq_o, TBL[r][4:0]);
        end

        // R3: reserved bits stay zero with everything set
        @(negedge clk);
        evt_i = 5'b11111; wr_en = 1'b0; ack_i = '0; gie_i = 1'b1; ie_mask_i = 5'b11111;
        @(posedge clk); #1;
        check8("R3", rd_data, 8'hEA);
        check5("R6", irq_o, 5'b11111);

        // R1: reset mid-run clears everything
        @(negedge clk);
        evt_i = '0;
        rst_n = 1'b0;
        #1;
        check8("R1", rd_data, 8'h00);
        check5("R1", irq_o, 5'b00000);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check8("R1", rd_data, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule